// File: doc/BRIEF.md
# Indexed-Colour Palette Expander

This block holds the colour table used by indexed-colour display modes. A host streams raw palette words into it after asking for a load. Each word is stored unchanged and is also expanded into 24-bit RGB plus a transparency flag, using one of four packed layouts. A greyscale override can replace that layout. A lookup port then turns a pixel index into its expanded colour one cycle later.

The bit depth, and with it the table size, comes from a 4-bit code carried in a control word. The raw words are kept after the load. Whenever the layout selection or the greyscale override changes, the block walks the stored entries and expands them again. Expanded colours live in two banks. Loads and re-expansions write the bank that lookups are not reading, and the banks swap only when the job is finished. Lookups therefore always see a complete, consistent table.

The palette input is a valid/ready stream. `pal_ready` is high only while a load is in progress. A word moves on each rising edge where both `pal_valid` and `pal_ready` are high. The source may drop `pal_valid` at any time to pause, and must hold `pal_data` steady while `pal_valid` is high and `pal_ready` is low. Words offered while no load is running are never taken. The lookup port has no back-pressure and accepts one index per cycle.

Top module: `palette_expander`

## Requirements
- R1: The depth code is `{ctl_word[29], ctl_word[26:24]}`. Code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. A `load_req` seen while idle with any other code is ignored: `pal_ready` stays low and the table is unchanged.
- R2: `pal_ready` is high only during a load. Words are taken in order into entries 0, 1, 2 and so on, one per edge where `pal_valid` and `pal_ready` are both high. A low `pal_valid` only pauses the load. Words offered outside a load are not taken. The load ends with the word for the last entry.
- R3: Layout 0 (`pal_fmt`=0): red = word[15:11], green = word[10:5], blue = word[4:0]. Transparency is always 0.
- R4: Layout 1: the colour fields are the same as layout 0, and transparency = word[24].
- R5: Layout 2: red = word[23:19], green = word[15:10], blue = word[7:3], transparency = word[24].
- R6: Layout 3: red = word[23:16], green = word[15:8], blue = word[7:0], transparency = word[24].
- R7: With `mono_en` high, red, green and blue all equal word[7:0], whatever the layout. Transparency still follows the layout. Every 5-bit field is widened by shifting it left 3 places, and every 6-bit field by shifting it left 2 places.
- R8: After a table has been loaded, a change of `pal_fmt` or `mono_en` re-expands the stored entries from their raw words. For an N-entry table the new colours are in place N+1 cycles after the change.
- R9: A lookup presented on one edge returns `lk_out_valid`, `lk_rgb` = {red, green, blue} and `lk_transp` after that edge. Index bits above the active table's depth are ignored.
- R10: Lookups made during a load or a re-expansion return the previous table. The new table serves lookups sampled on the first edge after its last entry is written.
- R11: After reset, `pal_ready`, `busy` and `lk_out_valid` are low and the colour outputs are zero. Lookups made before any completed load return zero.
- R12: `busy` is high while a load or re-expansion is running, or while a format change is waiting to be applied. It falls on the edge that completes the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 32 | Control word; only the depth-code bits are used |
| pal_fmt | input | 2 | Palette word layout select |
| mono_en | input | 1 | Greyscale override |
| load_req | input | 1 | Start a palette load (sampled while idle) |
| pal_valid | input | 1 | Palette word valid |
| pal_ready | output | 1 | Palette word accepted this edge when valid |
| pal_data | input | 32 | Raw palette word |
| busy | output | 1 | Load or re-expansion pending or running |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 8 | Pixel index to look up |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_rgb | output | 24 | Expanded colour {red, green, blue} |
| lk_transp | output | 1 | Expanded transparency flag |

## Verification
A lookup result is due one edge after the request, so the bench drives the index on a falling edge and compares at the next falling edge. The end of a load is due on the edge that accepts the final word: `busy` is checked low at the falling edge that follows, and every lookup after that must show the new table. A re-expansion of an N-entry table is checked by counting N falling edges with `busy` still high and one more with it low. Lookups issued part-way through a load or a re-expansion are compared with the model's old table. The bench updates its model only once the job is complete.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int RAW_W   = 25;
  localparam int CTL_W   = 32;
  localparam int DEPTH_TOP_BIT = 29;
  localparam int DEPTH_LO_MSB  = 26;
  localparam int DEPTH_LO_LSB  = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CONV = 2'd2
  } pal_state_e;

  typedef struct packed {
    logic       mono;
    logic [1:0] fmt;
  } pal_cfg_t;

  typedef struct packed {
    logic       transp;
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } pal_color_t;
endpackage

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  pal_cfg_t         cfg,
  output pal_color_t       color
);
  always_comb begin
    color.transp = (cfg.fmt == 2'd0) ? 1'b0 : raw[RAW_W-1];
    case (cfg.fmt)
      2'd0, 2'd1: begin
        color.red = {raw[15:11], 3'b000};
        color.grn = {raw[10:5], 2'b00};
        color.blu = {raw[4:0], 3'b000};
      end
      2'd2: begin
        color.red = {raw[23:19], 3'b000};
        color.grn = {raw[15:10], 2'b00};
        color.blu = {raw[7:3], 3'b000};
      end
      default: begin
        color.red = raw[23:16];
        color.grn = raw[15:8];
        color.blu = raw[7:0];
      end
    endcase
    if (cfg.mono) begin
      color.red = raw[7:0];
      color.grn = raw[7:0];
      color.blu = raw[7:0];
    end
  end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [3:0]       depth_code,
  input  pal_cfg_t         live_cfg,
  input  logic             pal_valid,
  output logic             pal_ready,
  output logic             busy,
  output logic             wr_en,
  output logic             wr_stream,
  output logic [IDX_W-1:0] wr_addr,
  output pal_cfg_t         job_cfg,
  output logic             act_bank,
  output logic [IDX_W-1:0] act_mask,
  output logic             tbl_loaded
);
  localparam int CNT_W = IDX_W + 1;

  pal_state_e       state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] job_cnt_q, act_cnt_q, new_cnt;
  logic             act_q, loaded_q;
  pal_cfg_t         applied_q, cur_q;
  logic             indexed, mismatch, step, last;
  logic [3:0]       bpp;

  always_comb begin
    indexed  = (depth_code == 4'd1) || (depth_code == 4'd2) || (depth_code == 4'd3);
    bpp      = 4'd1 << depth_code[1:0];
    new_cnt  = CNT_W'(1) << bpp;
    mismatch = loaded_q && (live_cfg != applied_q);
    step     = (state_q == ST_CONV) || ((state_q == ST_LOAD) && pal_valid);
    last     = ({1'b0, ptr_q} == (job_cnt_q - CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      job_cnt_q <= '0;
      act_cnt_q <= '0;
      act_q     <= 1'b0;
      loaded_q  <= 1'b0;
      applied_q <= '0;
      cur_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_req && indexed) begin
            state_q   <= ST_LOAD;
            ptr_q     <= '0;
            job_cnt_q <= new_cnt;
            cur_q     <= live_cfg;
          end else if (mismatch) begin
            state_q   <= ST_CONV;
            ptr_q     <= '0;
            job_cnt_q <= act_cnt_q;
            cur_q     <= live_cfg;
          end
        end
        default: begin
          if (step) begin
            ptr_q <= ptr_q + 1'b1;
            if (last) begin
              state_q   <= ST_IDLE;
              act_q     <= ~act_q;
              applied_q <= cur_q;
              if (state_q == ST_LOAD) begin
                act_cnt_q <= job_cnt_q;
                loaded_q  <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign pal_ready  = (state_q == ST_LOAD);
  assign busy       = (state_q != ST_IDLE) || mismatch;
  assign wr_en      = step;
  assign wr_stream  = (state_q == ST_LOAD);
  assign wr_addr    = ptr_q;
  assign job_cfg    = cur_q;
  assign act_bank   = act_q;
  assign act_mask   = act_cnt_q[IDX_W-1:0] - 1'b1;
  assign tbl_loaded = loaded_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_IDLE) |-> ({1'b0, ptr_q} < job_cnt_q)); // R2
  AST_BAD_DEPTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && load_req && !indexed && !mismatch) |=> (state_q == ST_IDLE)); // R1
  AST_SWAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (step && last) |=> (act_q != $past(act_q))); // R10
  AST_PAUSE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_LOAD && !pal_valid) |=> $stable(act_q)); // R10
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_stream,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [RAW_W-1:0] wr_raw,
  input  pal_color_t       wr_color,
  output logic [RAW_W-1:0] rd_raw,
  input  logic             rd_bank,
  input  logic [IDX_W-1:0] rd_mask,
  input  logic             tbl_loaded,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_index,
  output logic             lk_out_valid,
  output pal_color_t       lk_color
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RAW_W-1:0] raw_q  [DEPTH];
  pal_color_t       bank_q [2][DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && wr_stream) raw_q[wr_addr] <= wr_raw;
    if (wr_en) bank_q[~rd_bank][wr_addr] <= wr_color;
  end

  assign rd_raw = raw_q[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_out_valid <= 1'b0;
      lk_color     <= '0;
    end else begin
      lk_out_valid <= lk_valid;
      if (lk_valid) lk_color <= tbl_loaded ? bank_q[rd_bank][lk_index & rd_mask] : '0;
    end
  end

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> lk_out_valid); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> $stable(lk_color)); // R9
endmodule

// File: rtl/palette_expander.sv
module palette_expander
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [1:0]        pal_fmt,
  input  logic              mono_en,
  input  logic              load_req,
  input  logic              pal_valid,
  output logic              pal_ready,
  input  logic [DATA_W-1:0] pal_data,
  output logic              busy,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              lk_out_valid,
  output logic [23:0]       lk_rgb,
  output logic              lk_transp
);
  logic [3:0]       depth_code;
  pal_cfg_t         live_cfg, job_cfg;
  logic             wr_en, wr_stream, act_bank, tbl_loaded;
  logic [IDX_W-1:0] wr_addr, act_mask;
  logic [RAW_W-1:0] rd_raw, exp_raw;
  pal_color_t       exp_color, lk_color;
  logic             ctl_unused;

  assign depth_code = {ctl_word[DEPTH_TOP_BIT], ctl_word[DEPTH_LO_MSB:DEPTH_LO_LSB]};
  assign live_cfg   = '{mono: mono_en, fmt: pal_fmt};
  assign ctl_unused = ^{ctl_word[CTL_W-1:DEPTH_TOP_BIT+1], ctl_word[DEPTH_TOP_BIT-1:DEPTH_LO_MSB+1],
                        ctl_word[DEPTH_LO_LSB-1:0], pal_data[DATA_W-1:RAW_W]};

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .depth_code (depth_code),
    .live_cfg   (live_cfg),
    .pal_valid  (pal_valid),
    .pal_ready  (pal_ready),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_stream  (wr_stream),
    .wr_addr    (wr_addr),
    .job_cfg    (job_cfg),
    .act_bank   (act_bank),
    .act_mask   (act_mask),
    .tbl_loaded (tbl_loaded)
  );

  assign exp_raw = wr_stream ? pal_data[RAW_W-1:0] : rd_raw;

  pal_expand u_expand (
    .raw   (exp_raw),
    .cfg   (job_cfg),
    .color (exp_color)
  );

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_stream    (wr_stream),
    .wr_addr      (wr_addr),
    .wr_raw       (pal_data[RAW_W-1:0]),
    .wr_color     (exp_color),
    .rd_raw       (rd_raw),
    .rd_bank      (act_bank),
    .rd_mask      (act_mask),
    .tbl_loaded   (tbl_loaded),
    .lk_valid     (lk_valid),
    .lk_index     (lk_index),
    .lk_out_valid (lk_out_valid),
    .lk_color     (lk_color)
  );

  assign lk_rgb    = {lk_color.red, lk_color.grn, lk_color.blu};
  assign lk_transp = lk_color.transp;

  AST_READY_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pal_ready |-> busy); // R12
endmodule

// File: tb/tb_palette_expander.sv
module tb_palette_expander;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [1:0]  pal_fmt = 2'd3;
  logic        mono_en = 1'b0;
  logic        load_req = 1'b0;
  logic        pal_valid = 1'b0;
  logic        pal_ready;
  logic [31:0] pal_data = '0;
  logic        busy;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_index = '0;
  logic        lk_out_valid;
  logic [23:0] lk_rgb;
  logic        lk_transp;

  always #4 clk = ~clk;

  palette_expander dut (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .pal_fmt(pal_fmt), .mono_en(mono_en),
    .load_req(load_req), .pal_valid(pal_valid), .pal_ready(pal_ready), .pal_data(pal_data),
    .busy(busy), .lk_valid(lk_valid), .lk_index(lk_index), .lk_out_valid(lk_out_valid),
    .lk_rgb(lk_rgb), .lk_transp(lk_transp)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl_word [256];
  logic [31:0] new_word [256];
  int mdl_n = 1;
  int mdl_fmt = 3;
  bit mdl_mono = 1'b0;
  bit mdl_loaded = 1'b0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [24:0] exp_col(logic [31:0] w, int f, bit m);
    int r, g, b, t;
    t = (f == 0) ? 0 : int'((w >> 24) & 1);
    if (f == 0 || f == 1) begin
      r = int'((w >> 11) & 31) * 8; g = int'((w >> 5) & 63) * 4; b = int'(w & 31) * 8;
    end else if (f == 2) begin
      r = int'((w >> 19) & 31) * 8; g = int'((w >> 10) & 63) * 4; b = int'((w >> 3) & 31) * 8;
    end else begin
      r = int'((w >> 16) & 255); g = int'((w >> 8) & 255); b = int'(w & 255);
    end
    if (m) begin
      r = int'(w & 255); g = r; b = r;
    end
    return {t[0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic logic [24:0] mdl_lookup(int idx);
    if (!mdl_loaded) return '0;
    return exp_col(mdl_word[idx % mdl_n], mdl_fmt, mdl_mono);
  endfunction

  function automatic logic [31:0] mk_ctl(logic [3:0] code);
    logic [31:0] c;
    c = 32'h18C3_A55A;
    c[29] = code[3];
    c[26:24] = code[2:0];
    return c;
  endfunction

  task automatic look(int idx, string tag, logic [24:0] exp);
    lk_valid = 1'b1;
    lk_index = idx[7:0];
    @(negedge clk);
    lk_valid = 1'b0;
    chk(tag, {6'b0, lk_out_valid, lk_transp, lk_rgb}, {6'b0, 1'b1, exp});
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 256; i++) look(i, tag, mdl_lookup(i));
  endtask

  task automatic set_cfg(int f, bit m);
    pal_fmt = f[1:0];
    mono_en = m;
    #1;
    chk("R12", {31'b0, busy}, 32'd1);
    repeat (mdl_n) @(negedge clk);
    chk("R8", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R8", {31'b0, busy}, 32'd0);
    mdl_fmt = f;
    mdl_mono = m;
  endtask

  task automatic do_load(logic [3:0] code, int n, logic [31:0] seed, bit gap, string tag);
    ctl_word = mk_ctl(code);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk(tag, {31'b0, pal_ready}, 32'd1);
    for (int i = 0; i < n; i++) begin
      if (gap && (i % 5 == 2)) begin
        pal_valid = 1'b0;
        pal_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R2", {31'b0, pal_ready}, 32'd1);
      end
      new_word[i] = (i * 32'h9E37_79B1) ^ seed;
      pal_valid = 1'b1;
      pal_data = new_word[i];
      @(negedge clk);
    end
    pal_valid = 1'b0;
    chk("R12", {31'b0, busy}, 32'd0);
    chk(tag, {31'b0, pal_ready}, 32'd0);
    for (int i = 0; i < n; i++) mdl_word[i] = new_word[i];
    mdl_n = n;
    mdl_loaded = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {29'b0, pal_ready, busy, lk_out_valid}, 32'd0);
    chk("R11", {7'b0, lk_transp, lk_rgb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {30'b0, pal_ready, busy}, 32'd0);
    look(5, "R11", 25'd0);

    // R1/R2/R6: full 256-entry load with gaps, layout 3
    do_load(4'd3, 256, 32'h5A17_C3E9, 1'b1, "R2");
    check_all("R6");

    // R8 with each layout and greyscale
    set_cfg(0, 1'b0); check_all("R3");
    set_cfg(1, 1'b0); check_all("R4");
    set_cfg(2, 1'b0); check_all("R5");
    set_cfg(3, 1'b1); check_all("R7");
    set_cfg(0, 1'b1); check_all("R7");
    set_cfg(3, 1'b0); check_all("R8");

    // R9: 4-entry table, high index bits ignored
    do_load(4'd1, 4, 32'h0123_4567, 1'b0, "R1");
    check_all("R9");

    // R1: non-indexed codes ignored (code 4, and code 9 with the top bit set)
    ctl_word = mk_ctl(4'd4);
    load_req = 1'b1; @(negedge clk); load_req = 1'b0;
    chk("R1", {30'b0, pal_ready, busy}, 32'd0);
    ctl_word = mk_ctl(4'd9);
    load_req = 1'b1; @(negedge clk); load_req = 1'b0;
    chk("R1", {30'b0, pal_ready, busy}, 32'd0);
    check_all("R1");

    // R2: words offered while idle are not taken
    pal_valid = 1'b1;
    pal_data = 32'hFFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      chk("R2", {31'b0, pal_ready}, 32'd0);
    end
    pal_valid = 1'b0;
    check_all("R2");

    // R10: lookup during a load sees the old table
    ctl_word = mk_ctl(4'd2);
    load_req = 1'b1; @(negedge clk); load_req = 1'b0;
    for (int i = 0; i < 16; i++) new_word[i] = (i * 32'h0101_0107) ^ 32'h0100_9C3F;
    for (int i = 0; i < 8; i++) begin
      pal_valid = 1'b1; pal_data = new_word[i]; @(negedge clk);
    end
    pal_valid = 1'b0;
    chk("R12", {31'b0, busy}, 32'd1);
    look(1, "R10", mdl_lookup(1));
    look(6, "R10", mdl_lookup(6));
    for (int i = 8; i < 16; i++) begin
      pal_valid = 1'b1; pal_data = new_word[i]; @(negedge clk);
    end
    pal_valid = 1'b0;
    chk("R12", {31'b0, busy}, 32'd0);
    for (int i = 0; i < 16; i++) mdl_word[i] = new_word[i];
    mdl_n = 16;
    look(6, "R10", mdl_lookup(6));
    check_all("R1");

    // R10: lookup during a re-expansion sees the old layout
    pal_fmt = 2'd2;
    @(negedge clk);
    @(negedge clk);
    look(4, "R10", mdl_lookup(4));
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    chk("R8", {31'b0, busy}, 32'd0);
    mdl_fmt = 2;
    check_all("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule